// File: doc/BRIEF.md
# Configurable CRC Calculation Engine

The engine keeps a running cyclic redundancy checksum. Data is written through a valid/ready port in words of 8, 16 or 32 bits. Each clock folds one byte into the checksum register. A narrow write finishes in the cycle it is accepted. A wider write keeps the port stalled until its remaining bytes have been folded in.

Configuration inputs do four things:

- pick one of four standard generator polynomials at run time;
- load a seed, or restart from the stored seed;
- enable bit reversal and one's complement on the incoming bytes;
- enable bit reversal and one's complement, separately, on the checksum as it is read out.

The read-out path is purely combinational. Observing it never changes the internal register.

Top module: `crc_engine`

## Requirements
- R1: A synchronous active-high reset sets the stored seed and the checksum register to all ones and clears any pending work. One cycle later `wr_ready` is high.
- R2: `cfg_poly` selects the generator polynomial and the active width: 0 = 0x1021 (16 bits), 1 = 0x07 (8 bits), 2 = 0x8005 (16 bits), 3 = 0x04C11DB7 (32 bits). Bytes are folded in most significant bit first, without reflection, and the checksum register is masked to the active width.
- R3: `wr_width` encodes the word size: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. An accepted write folds one byte per clock, starting in the accept cycle. After the accept, `wr_ready` stays low for 0, 1 or 3 cycles respectively.
- R4: Within a word, byte 0 (bits 7:0) is processed first and the most significant byte last.
- R5: When `cfg_in_rev` is 1, the bit order of each input byte is mirrored before it is folded in.
- R6: When `cfg_in_inv` is 1, each input byte is inverted before it is folded in.
- R7: When `cfg_out_rev` is 1, `crc_out` presents the active-width checksum with its bits mirrored across that width.
- R8: When `cfg_out_inv` is 1, `crc_out` presents the one's complement of the active-width value. Bits of `crc_out` above the active width are always 0.
- R9: A cycle with `seed_load` high stores `seed_val`. It also loads `seed_val` masked to the active width into the checksum register and abandons any bytes still pending. `wr_ready` is low in that cycle.
- R10: A cycle with `restart` high (and `seed_load` low) reloads the stored seed, masked to the active width, and abandons pending bytes. `wr_ready` is low in that cycle.
- R11: A write offered while `wr_ready` is low has no effect. An idle cycle leaves the checksum unchanged.
- R12: The input-side options and the polynomial used for a word are those present in its accept cycle. The output options and the output width follow the current configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_poly | input | 2 | Polynomial select |
| cfg_in_rev | input | 1 | Mirror bits of each input byte |
| cfg_in_inv | input | 1 | Invert each input byte |
| cfg_out_rev | input | 1 | Mirror checksum on read-out |
| cfg_out_inv | input | 1 | Invert checksum on read-out |
| seed_load | input | 1 | Store seed_val and load it as the checksum |
| seed_val | input | 32 | Seed value |
| restart | input | 1 | Reload checksum from stored seed |
| wr_valid | input | 1 | Write data offered |
| wr_width | input | 2 | Write word size code |
| wr_data | input | 32 | Write data |
| wr_ready | output | 1 | Engine can accept a write this cycle |
| crc_out | output | 32 | Post-processed checksum |

## Verification
A wrong checksum register bit shows up on `crc_out` in the very next cycle, because the read-out is combinational. A behavioural model is compared against the port on every clock, so a corrupted fold or a mis-masked seed is reported within one cycle.

A wrong byte counter shows up on `wr_ready` one cycle after an accept. It also shows up on `crc_out` as a byte folded in too often or too rarely. Published check values for the standard string "123456789" pin down the polynomials, the reflections and the byte order, independently of the model.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int CRC_MAX  = 32;
    localparam int BYTE_W   = 8;
    localparam int DATA_W   = 32;
    localparam int NBYTES   = DATA_W / BYTE_W;
    localparam int CNT_W    = $clog2(NBYTES + 1);
    localparam int TOP_W    = $clog2(CRC_MAX);
    localparam int BITS_W   = $clog2(CRC_MAX + 1);

    typedef logic [CRC_MAX-1:0] crc_word_t;

    typedef enum logic [1:0] {
        POLY_CCITT = 2'd0,
        POLY_C8    = 2'd1,
        POLY_C16   = 2'd2,
        POLY_C32   = 2'd3
    } poly_e;

    typedef enum logic [1:0] {
        WID_8   = 2'd0,
        WID_16  = 2'd1,
        WID_32  = 2'd2,
        WID_32B = 2'd3
    } wid_e;

    typedef struct packed {
        poly_e poly;
        logic  in_rev;
        logic  in_inv;
    } in_cfg_t;

    function automatic crc_word_t poly_coef(input poly_e p);
        case (p)
            POLY_CCITT: return 32'h0000_1021;
            POLY_C8:    return 32'h0000_0007;
            POLY_C16:   return 32'h0000_8005;
            default:    return 32'h04C1_1DB7;
        endcase
    endfunction

    function automatic logic [BITS_W-1:0] poly_bits(input poly_e p);
        case (p)
            POLY_C8:  return BITS_W'(8);
            POLY_C32: return BITS_W'(32);
            default:  return BITS_W'(16);
        endcase
    endfunction

    function automatic logic [TOP_W-1:0] poly_top(input poly_e p);
        return TOP_W'(poly_bits(p) - 1'b1);
    endfunction

    function automatic crc_word_t poly_mask(input poly_e p);
        return crc_word_t'({CRC_MAX{1'b1}}) >> (BITS_W'(CRC_MAX) - poly_bits(p));
    endfunction

    function automatic logic [CNT_W-1:0] word_bytes(input wid_e w);
        case (w)
            WID_8:   return CNT_W'(1);
            WID_16:  return CNT_W'(2);
            default: return CNT_W'(NBYTES);
        endcase
    endfunction

endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step
    import crc_pkg::*;
(
    input  crc_word_t          crc_in,
    input  logic [BYTE_W-1:0]  byte_in,
    input  in_cfg_t            cfg,
    output crc_word_t          crc_next
);
    logic [BYTE_W-1:0] b_inv;
    logic [BYTE_W-1:0] b_rev;
    logic [BYTE_W-1:0] b_use;
    crc_word_t         coef;
    crc_word_t         mask;
    logic [TOP_W-1:0]  top;
    crc_word_t         stage [0:BYTE_W];

    assign b_inv = byte_in ^ {BYTE_W{cfg.in_inv}};

    for (genvar g = 0; g < BYTE_W; g++) begin : g_mirror
        assign b_rev[g] = b_inv[BYTE_W-1-g];
    end

    assign b_use = cfg.in_rev ? b_rev : b_inv;
    assign coef  = poly_coef(cfg.poly);
    assign mask  = poly_mask(cfg.poly);
    assign top   = poly_top(cfg.poly);

    always_comb begin
        stage[0] = crc_in;
        for (int k = 0; k < BYTE_W; k++) begin
            stage[k+1] = ((stage[k] << 1) & mask)
                       ^ ((stage[k][top] ^ b_use[BYTE_W-1-k]) ? coef : '0);
        end
    end

    assign crc_next = stage[BYTE_W];

endmodule

// File: rtl/crc_word_seq.sv
module crc_word_seq
    import crc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               wr_valid,
    input  wid_e               wr_width,
    input  logic [DATA_W-1:0]  wr_data,
    input  in_cfg_t            cfg_now,
    output logic               wr_ready,
    output logic               step_en,
    output logic [BYTE_W-1:0]  cur_byte,
    output in_cfg_t            cur_cfg
);
    logic [DATA_W-1:0] hold_word;
    logic [CNT_W-1:0]  left;
    in_cfg_t           held_cfg;
    logic              accept;

    assign wr_ready = (left == '0) && !flush;
    assign accept   = wr_valid && wr_ready;
    assign step_en  = accept || ((left != '0) && !flush);
    assign cur_byte = accept ? wr_data[BYTE_W-1:0] : hold_word[BYTE_W-1:0];
    assign cur_cfg  = accept ? cfg_now : held_cfg;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            left      <= '0;
            hold_word <= '0;
            held_cfg  <= '0;
        end else if (accept) begin
            hold_word <= wr_data >> BYTE_W;
            left      <= word_bytes(wr_width) - 1'b1;
            held_cfg  <= cfg_now;
        end else if (left != '0) begin
            hold_word <= hold_word >> BYTE_W;
            left      <= left - 1'b1;
        end
    end

    AST_WIDE_STALLS: assert property (@(posedge clk) disable iff (rst)
        accept && (wr_width == WID_32 || wr_width == WID_32B) |=> !wr_ready); // R3

    AST_NARROW_FREES: assert property (@(posedge clk) disable iff (rst)
        accept && (wr_width == WID_8) |=> (wr_ready || flush)); // R3

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (left != '0) |-> !wr_ready); // R11

endmodule

// File: rtl/crc_out_stage.sv
module crc_out_stage
    import crc_pkg::*;
(
    input  crc_word_t crc_reg,
    input  poly_e     poly,
    input  logic      out_rev,
    input  logic      out_inv,
    output crc_word_t crc_out
);
    crc_word_t mask;
    crc_word_t val;
    crc_word_t mirrored;
    crc_word_t aligned;
    crc_word_t chosen;

    assign mask = poly_mask(poly);
    assign val  = crc_reg & mask;

    for (genvar g = 0; g < CRC_MAX; g++) begin : g_mirror
        assign mirrored[g] = val[CRC_MAX-1-g];
    end

    assign aligned = mirrored >> (BITS_W'(CRC_MAX) - poly_bits(poly));
    assign chosen  = out_rev ? aligned : val;
    assign crc_out = out_inv ? (chosen ^ mask) : chosen;

endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_poly,
    input  logic        cfg_in_rev,
    input  logic        cfg_in_inv,
    input  logic        cfg_out_rev,
    input  logic        cfg_out_inv,
    input  logic        seed_load,
    input  logic [31:0] seed_val,
    input  logic        restart,
    input  logic        wr_valid,
    input  logic [1:0]  wr_width,
    input  logic [31:0] wr_data,
    output logic        wr_ready,
    output logic [31:0] crc_out
);
    crc_word_t         crc_reg;
    crc_word_t         seed_reg;
    crc_word_t         crc_step;
    poly_e             poly_now;
    in_cfg_t           cfg_now;
    in_cfg_t           cur_cfg;
    logic              step_en;
    logic [BYTE_W-1:0] cur_byte;

    assign poly_now = poly_e'(cfg_poly);
    assign cfg_now  = '{poly: poly_now, in_rev: cfg_in_rev, in_inv: cfg_in_inv};

    crc_word_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .flush    (seed_load || restart),
        .wr_valid (wr_valid),
        .wr_width (wid_e'(wr_width)),
        .wr_data  (wr_data),
        .cfg_now  (cfg_now),
        .wr_ready (wr_ready),
        .step_en  (step_en),
        .cur_byte (cur_byte),
        .cur_cfg  (cur_cfg)
    );

    crc_byte_step i_step (
        .crc_in   (crc_reg),
        .byte_in  (cur_byte),
        .cfg      (cur_cfg),
        .crc_next (crc_step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_reg  <= '1;
            seed_reg <= '1;
        end else if (seed_load) begin
            seed_reg <= seed_val;
            crc_reg  <= seed_val & poly_mask(poly_now);
        end else if (restart) begin
            crc_reg  <= seed_reg & poly_mask(poly_now);
        end else if (step_en) begin
            crc_reg  <= crc_step;
        end
    end

    crc_out_stage i_out (
        .crc_reg (crc_reg),
        .poly    (poly_now),
        .out_rev (cfg_out_rev),
        .out_inv (cfg_out_inv),
        .crc_out (crc_out)
    );

    AST_RESET_READY: assert property (@(posedge clk)
        rst |=> (wr_ready || seed_load || restart)); // R1

    AST_SEED_TAKES: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> crc_reg == ($past(seed_val) & poly_mask(poly_e'($past(cfg_poly))))); // R9

    AST_RESTART_RELOADS: assert property (@(posedge clk) disable iff (rst)
        restart && !seed_load |=> crc_reg == ($past(seed_reg) & poly_mask(poly_e'($past(cfg_poly))))); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !step_en && !seed_load && !restart |=> $stable(crc_reg)); // R11

endmodule

// File: tb/test_crc_engine.sv
module test_crc_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_poly;
    logic        cfg_in_rev, cfg_in_inv, cfg_out_rev, cfg_out_inv;
    logic        seed_load, restart, wr_valid;
    logic [31:0] seed_val, wr_data;
    logic [1:0]  wr_width;
    logic        wr_ready;
    logic [31:0] crc_out;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // behavioural model state
    logic [31:0] m_crc, m_seed;
    logic [7:0]  m_q[$];
    logic [1:0]  m_lp;
    logic        m_lrv, m_liv;
    bit          m_valid = 0;

    always #5 clk = ~clk;

    crc_engine i_crc_engine (
        .clk(clk), .rst(rst), .cfg_poly(cfg_poly),
        .cfg_in_rev(cfg_in_rev), .cfg_in_inv(cfg_in_inv),
        .cfg_out_rev(cfg_out_rev), .cfg_out_inv(cfg_out_inv),
        .seed_load(seed_load), .seed_val(seed_val), .restart(restart),
        .wr_valid(wr_valid), .wr_width(wr_width), .wr_data(wr_data),
        .wr_ready(wr_ready), .crc_out(crc_out)
    );

    function automatic int m_bits(input logic [1:0] p);
        return (p == 2'd1) ? 8 : (p == 2'd3) ? 32 : 16;
    endfunction

    function automatic logic [31:0] m_mask(input logic [1:0] p);
        logic [63:0] one = 64'd1;
        return 32'((one << m_bits(p)) - 64'd1);
    endfunction

    function automatic logic [31:0] m_gen(input logic [1:0] p);
        case (p)
            2'd0: return 32'h1021;
            2'd1: return 32'h07;
            2'd2: return 32'h8005;
            default: return 32'h04C11DB7;
        endcase
    endfunction

    function automatic logic [31:0] m_fold(input logic [31:0] c, input logic [7:0] b,
                                           input logic [1:0] p, input logic rv, input logic iv);
        logic [7:0] x;
        int w;
        logic fb;
        w = m_bits(p);
        x = iv ? ~b : b;
        if (rv) begin
            logic [7:0] t;
            for (int i = 0; i < 8; i++) t[i] = x[7-i];
            x = t;
        end
        for (int i = 7; i >= 0; i--) begin
            fb = c[w-1] ^ x[i];
            c = (c << 1) & m_mask(p);
            if (fb) c = c ^ m_gen(p);
        end
        return c & m_mask(p);
    endfunction

    function automatic logic [31:0] m_post(input logic [31:0] c, input logic [1:0] p,
                                           input logic rv, input logic iv);
        logic [31:0] v, r;
        int w;
        w = m_bits(p);
        v = c & m_mask(p);
        if (rv) begin
            r = '0;
            for (int i = 0; i < w; i++) r[i] = v[w-1-i];
            v = r;
        end
        if (iv) v = v ^ m_mask(p);
        return v;
    endfunction

    task automatic compare_now();
        logic exp_rdy;
        logic [31:0] exp_out;
        if (!m_valid || rst) return;
        exp_rdy = (m_q.size() == 0) && !seed_load && !restart;
        exp_out = m_post(m_crc, cfg_poly, cfg_out_rev, cfg_out_inv);
        checks++;
        if (wr_ready !== exp_rdy) begin
            errors++;
            $display("FAIL %s wr_ready actual=%0b expected=%0b t=%0t", phase, wr_ready, exp_rdy, $time);
        end
        checks++;
        if (crc_out !== exp_out) begin
            errors++;
            $display("FAIL %s crc_out actual=%h expected=%h t=%0t", phase, crc_out, exp_out, $time);
        end
    endtask

    task automatic model_edge(input logic r, input logic sl, input logic rs, input logic wv,
                              input logic [1:0] ww, input logic [31:0] wd, input logic [31:0] sv,
                              input logic [1:0] p, input logic irv, input logic iiv);
        int n;
        if (r) begin
            m_crc = '1; m_seed = '1; m_q.delete(); m_valid = 1;
        end else if (sl) begin
            m_seed = sv; m_crc = sv & m_mask(p); m_q.delete();
        end else if (rs) begin
            m_crc = m_seed & m_mask(p); m_q.delete();
        end else if (m_q.size() > 0) begin
            m_crc = m_fold(m_crc, m_q.pop_front(), m_lp, m_lrv, m_liv);
        end else if (wv) begin
            n = (ww == 2'd0) ? 1 : (ww == 2'd1) ? 2 : 4;
            for (int i = 1; i < n; i++) m_q.push_back(wd[8*i +: 8]);
            m_lp = p; m_lrv = irv; m_liv = iiv;
            m_crc = m_fold(m_crc, wd[7:0], p, irv, iiv);
        end
    endtask

    // one clock: compare before the edge, update the model at the edge
    task automatic cyc();
        logic r, sl, rs, wv, irv, iiv;
        logic [1:0] ww, p;
        logic [31:0] wd, sv;
        #1;
        compare_now();
        r = rst; sl = seed_load; rs = restart; wv = wr_valid; ww = wr_width;
        wd = wr_data; sv = seed_val; p = cfg_poly; irv = cfg_in_rev; iiv = cfg_in_inv;
        @(posedge clk);
        model_edge(r, sl, rs, wv, ww, wd, sv, p, irv, iiv);
        @(negedge clk);
    endtask

    task automatic check_val(input logic [31:0] exp, input string tag);
        #1;
        checks++;
        if (crc_out !== exp) begin
            errors++;
            $display("FAIL %s known value actual=%h expected=%h", tag, crc_out, exp);
        end
    endtask

    task automatic check_rdy(input logic exp, input string tag);
        #1;
        checks++;
        if (wr_ready !== exp) begin
            errors++;
            $display("FAIL %s ready actual=%0b expected=%0b", tag, wr_ready, exp);
        end
    endtask

    task automatic put_word(input logic [31:0] d, input logic [1:0] w);
        int n;
        n = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
        wr_valid = 1; wr_data = d; wr_width = w;
        cyc();
        wr_valid = 0;
        for (int i = 1; i < n; i++) cyc();
    endtask

    task automatic load_seed(input logic [31:0] s);
        seed_load = 1; seed_val = s;
        cyc();
        seed_load = 0;
    endtask

    task automatic put_check_string();
        string s = "123456789";
        for (int i = 0; i < 9; i++) put_word({24'd0, s[i]}, 2'd0);
    endtask

    task automatic set_cfg(input logic [1:0] p, input logic irv, input logic iiv,
                           input logic orv, input logic oiv);
        cfg_poly = p; cfg_in_rev = irv; cfg_in_inv = iiv; cfg_out_rev = orv; cfg_out_inv = oiv;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; seed_load = 0; restart = 0; wr_valid = 0; wr_width = 0;
        wr_data = 0; seed_val = 0;
        set_cfg(2'd3, 0, 0, 0, 0);
        @(negedge clk);
        cyc(); cyc();
        rst = 0;
        // R1: reset state
        phase = "R1";
        check_rdy(1'b1, "R1");
        check_val(32'hFFFF_FFFF, "R1");
        cfg_poly = 2'd1;
        check_val(32'h0000_00FF, "R1 R8");
        cyc();

        // R2: CRC-16 0x1021, seed FFFF, "123456789" -> 29B1
        phase = "R2";
        set_cfg(2'd0, 0, 0, 0, 0);
        load_seed(32'h0000_FFFF);
        put_check_string();
        check_val(32'h0000_29B1, "R2");
        cyc();

        // R2: CRC-8 0x07 seed 0 -> F4
        set_cfg(2'd1, 0, 0, 0, 0);
        load_seed(32'h0);
        put_check_string();
        check_val(32'h0000_00F4, "R2");
        cyc();

        // R5 R7: 0x8005 reflected, seed 0 -> BB3D
        phase = "R5";
        set_cfg(2'd2, 1, 0, 1, 0);
        load_seed(32'h0);
        put_check_string();
        check_val(32'h0000_BB3D, "R5 R7");
        cyc();

        // R5 R7 R8: CRC-32 reflected, seed all ones, inverted out -> CBF43926
        phase = "R8";
        set_cfg(2'd3, 1, 0, 1, 1);
        load_seed(32'hFFFF_FFFF);
        put_check_string();
        check_val(32'hCBF4_3926, "R5 R7 R8");
        cyc();

        // R3 R4: same string as 32-bit words, LSB first, plus a final byte
        phase = "R4";
        load_seed(32'hFFFF_FFFF);
        wr_valid = 1; wr_data = 32'h3433_3231; wr_width = 2'd2;
        cyc();
        wr_valid = 0;
        check_rdy(1'b0, "R3");
        cyc(); cyc();
        check_rdy(1'b0, "R3");
        cyc();
        check_rdy(1'b1, "R3");
        put_word(32'h3837_3635, 2'd3);
        put_word(32'h0000_0039, 2'd0);
        check_val(32'hCBF4_3926, "R3 R4");
        cyc();

        // R3 R4: 16-bit words "12","34",... then "9"
        load_seed(32'hFFFF_FFFF);
        put_word(32'h0000_3231, 2'd1);
        put_word(32'h0000_3433, 2'd1);
        put_word(32'h0000_3635, 2'd1);
        put_word(32'h0000_3837, 2'd1);
        put_word(32'h0000_0039, 2'd0);
        check_val(32'hCBF4_3926, "R3 R4");
        cyc();

        // R6: inverted input bytes equal plain check string with complement
        phase = "R6";
        set_cfg(2'd3, 1, 1, 1, 1);
        load_seed(32'hFFFF_FFFF);
        begin
            string s = "123456789";
            for (int i = 0; i < 9; i++) put_word({24'hFFFFFF, ~s[i]}, 2'd0);
        end
        check_val(32'hCBF4_3926, "R6");
        cyc();

        // R11: writes offered during a stall are ignored
        phase = "R11";
        set_cfg(2'd3, 0, 0, 0, 0);
        load_seed(32'h1234_5678);
        wr_valid = 1; wr_data = 32'hDEAD_BEEF; wr_width = 2'd2;
        cyc();
        wr_data = 32'h0BAD_F00D; wr_width = 2'd0;
        cyc(); cyc(); cyc();
        wr_valid = 0;
        repeat (3) cyc();

        // R9 R10: seed load and restart abort a word in progress
        phase = "R9";
        wr_valid = 1; wr_data = 32'hA5A5_5A5A; wr_width = 2'd2;
        cyc();
        wr_valid = 0;
        seed_load = 1; seed_val = 32'hCAFE_0042; cfg_poly = 2'd1;
        check_rdy(1'b0, "R9");
        cyc();
        seed_load = 0;
        check_val(32'h0000_0042, "R9");
        check_rdy(1'b1, "R9");
        phase = "R10";
        cfg_poly = 2'd3;
        put_word(32'h1111_2222, 2'd2);
        wr_valid = 1; wr_data = 32'h7777_8888; wr_width = 2'd2;
        cyc();
        wr_valid = 0;
        restart = 1;
        check_rdy(1'b0, "R10");
        cyc();
        restart = 0;
        check_val(32'hCAFE_0042, "R10");
        cyc();

        // R12 and mixed traffic: random configuration changes at any time
        phase = "R12";
        for (int i = 0; i < 4000; i++) begin
            seed_load = ($urandom_range(0, 99) < 3);
            restart   = ($urandom_range(0, 99) < 3);
            seed_val  = $urandom;
            wr_valid  = ($urandom_range(0, 99) < 60);
            wr_width  = 2'($urandom_range(0, 3));
            wr_data   = $urandom;
            if ($urandom_range(0, 9) == 0)
                set_cfg(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                        1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            cyc();
        end
        seed_load = 0; restart = 0; wr_valid = 0;
        repeat (4) cyc();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule